// File: doc/BRIEF.md
# Ring-Token Depth Expansion Controller

This block sits beside the storage array of one FIFO slice. It decides when that slice may accept a write or deliver a read. Several slices can be linked in a ring so that together they act as one FIFO whose depth is the sum of theirs. Write ownership and read ownership each travel round the ring as a token. A slice keeps the write token until it stores a word in its highest physical address. On that same edge it releases the token and emits a one-cycle pulse on its write-chain output. The next slice samples that pulse on the following edge and takes the token. Read ownership moves in the same way, driven by reads of the highest address. Words therefore leave the ring in the order they entered it.

A strap marks the slice that owns both tokens after reset. That slice has `first_load` low; every other slice has it high. The parameter `CHAINED` chooses the variant. When it is 0, the slice runs alone with its chain inputs tied low. It then keeps both tokens for good, lets its addresses wrap, and drives the half-full flag on the shared `xo_hf` pin instead of the write pulse. The controller also produces the slice's write and read addresses, its fill level flags and the gated enables that the storage array uses. Ring-wide full and empty are formed outside the block by combining the flags of all slices.

Top module: `xchain_ctrl`

## Requirements
- R1: After reset, a CHAINED slice with `first_load` low owns both tokens, and one with `first_load` high owns neither. Every slice is empty, both addresses are 0, and `xo_hf` and `rd_xout` are low.
- R2: `wr_go` is high in a cycle exactly when `wr_owner` is high, `wr_req` is high and `slice_full` is low. A write request to a slice without the token is ignored.
- R3: `rd_go` is high in a cycle exactly when `rd_owner` is high, `rd_req` is high and `slice_empty` is low. A read request to a slice without the token is ignored.
- R4: In CHAINED mode, a write at address DEPTH-1 clears `wr_owner` on that edge. It also drives `xo_hf` high for exactly the next cycle.
- R5: In CHAINED mode, a read at address DEPTH-1 clears `rd_owner` on that edge. It also drives `rd_xout` high for exactly the next cycle.
- R6: A slice that samples `wr_xin` (or `rd_xin`) high on a clock edge owns the write (or read) token from that edge on.
- R7: Each accepted write advances `wr_addr` by one, and each accepted read advances `rd_addr` by one. Both wrap from DEPTH-1 to 0.
- R8: With CHAINED=0, the slice always owns both tokens and `rd_xout` stays low. `xo_hf` is high exactly while the stored count exceeds DEPTH/2.
- R9: `slice_full` is high exactly when DEPTH words are stored, and `slice_empty` is high exactly when none are.
- R10: A ring of three slices delivers every accepted word exactly once and in acceptance order, across slice boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| first_load | input | 1 | Strap: low on the slice that starts with both tokens |
| wr_xin | input | 1 | Write token pulse from the previous slice |
| rd_xin | input | 1 | Read token pulse from the previous slice |
| wr_req | input | 1 | Ring-wide write request |
| rd_req | input | 1 | Ring-wide read request |
| wr_go | output | 1 | This slice accepts the write this cycle |
| rd_go | output | 1 | This slice delivers a read this cycle |
| wr_addr | output | $clog2(DEPTH) | Local write address |
| rd_addr | output | $clog2(DEPTH) | Local read address |
| wr_owner | output | 1 | Slice holds the write token |
| rd_owner | output | 1 | Slice holds the read token |
| slice_full | output | 1 | DEPTH words stored locally |
| slice_empty | output | 1 | No words stored locally |
| xo_hf | output | 1 | Write token pulse (CHAINED) or half-full flag (single) |
| rd_xout | output | 1 | Read token pulse to the next slice |

## Verification
The hardest case to reach is a token arriving at a slice that is still full from the previous lap. In that case the write must stall with no slice accepting, and the handover cycle itself drops a request. The bench fills the ring with writes alone, so the write token makes a full lap and returns to a full first slice. It then drains with reads alone and runs long stretches of mixed and pseudo-random traffic. A behavioural model of owners, addresses and counts is compared every cycle, and a stored copy of each slice's contents confirms the output order.

// File: rtl/xchain_pkg.sv
package xchain_pkg;
  function automatic int ptr_w(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
  function automatic int lvl_w(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/xchain_token.sv
module xchain_token
  import xchain_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter bit CHAINED = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     first_load,
  input  logic                     x_in,
  input  logic                     req,
  input  logic                     blocked,
  output logic                     own,
  output logic                     fire,
  output logic [ptr_w(DEPTH)-1:0]  ptr,
  output logic                     x_out
);
  localparam int PW = ptr_w(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic at_last;
  assign at_last = (ptr == LAST);
  assign fire    = own && req && !blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      own   <= CHAINED ? !first_load : 1'b1;
      ptr   <= '0;
      x_out <= 1'b0;
    end else begin
      x_out <= 1'b0;
      if (fire) ptr <= at_last ? '0 : ptr + 1'b1;
      if (CHAINED) begin
        if (fire && at_last) begin
          own   <= 1'b0;
          x_out <= 1'b1;
        end
        if (x_in) own <= 1'b1;
      end
    end
  end

  assert_ptr_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && at_last) |=> (ptr == '0));

  generate
    if (CHAINED) begin : g_chk_chain
      assert_pulse_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        x_out |=> !x_out);
      assert_release_with_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(own) |-> x_out);
      assert_take_on_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        x_in |=> own);
    end else begin : g_chk_single
      assert_always_owner_R8: assert property (@(posedge clk) disable iff (rst)
        own && !x_out);
    end
  endgenerate
endmodule

// File: rtl/xchain_level.sv
module xchain_level
  import xchain_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_fire,
  input  logic rd_fire,
  output logic full,
  output logic empty,
  output logic half_full
);
  localparam int LW = lvl_w(DEPTH);
  localparam logic [LW-1:0] TOP  = LW'(DEPTH);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);

  logic [LW-1:0] level, level_nxt;

  always_comb begin
    level_nxt = level;
    if (wr_fire && !rd_fire) level_nxt = level + 1'b1;
    else if (rd_fire && !wr_fire) level_nxt = level - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level     <= '0;
      half_full <= 1'b0;
    end else begin
      level     <= level_nxt;
      half_full <= (level_nxt > HALF);
    end
  end

  assign full  = (level == TOP);
  assign empty = (level == '0);

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (rst)
    level <= TOP);
  assert_no_wr_when_full_R9: assert property (@(posedge clk) disable iff (rst)
    full |-> !wr_fire);
  assert_hf_not_empty_R8: assert property (@(posedge clk) disable iff (rst)
    half_full |-> !empty);
endmodule

// File: rtl/xchain_ctrl.sv
module xchain_ctrl
  import xchain_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter bit CHAINED = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    first_load,
  input  logic                    wr_xin,
  input  logic                    rd_xin,
  input  logic                    wr_req,
  input  logic                    rd_req,
  output logic                    wr_go,
  output logic                    rd_go,
  output logic [ptr_w(DEPTH)-1:0] wr_addr,
  output logic [ptr_w(DEPTH)-1:0] rd_addr,
  output logic                    wr_owner,
  output logic                    rd_owner,
  output logic                    slice_full,
  output logic                    slice_empty,
  output logic                    xo_hf,
  output logic                    rd_xout
);
  logic wr_pulse, rd_pulse, half_full;

  xchain_token #(.DEPTH(DEPTH), .CHAINED(CHAINED)) u_wr_tok (
    .clk(clk), .rst(rst), .first_load(first_load), .x_in(wr_xin),
    .req(wr_req), .blocked(slice_full), .own(wr_owner), .fire(wr_go),
    .ptr(wr_addr), .x_out(wr_pulse));

  xchain_token #(.DEPTH(DEPTH), .CHAINED(CHAINED)) u_rd_tok (
    .clk(clk), .rst(rst), .first_load(first_load), .x_in(rd_xin),
    .req(rd_req), .blocked(slice_empty), .own(rd_owner), .fire(rd_go),
    .ptr(rd_addr), .x_out(rd_pulse));

  xchain_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst(rst), .wr_fire(wr_go), .rd_fire(rd_go),
    .full(slice_full), .empty(slice_empty), .half_full(half_full));

  generate
    if (CHAINED) begin : g_pin_chain
      assign xo_hf = wr_pulse;
    end else begin : g_pin_single
      assign xo_hf = half_full;
    end
  endgenerate
  assign rd_xout = rd_pulse;

  assert_wr_gated_R2: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> (wr_owner && !slice_full));
  assert_rd_gated_R3: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> (rd_owner && !slice_empty));
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(slice_full && slice_empty));
endmodule

// File: tb/xchain_ctrl_bench.sv
module xchain_ctrl_bench;
  localparam int D = 4;
  localparam int N = 3;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic wr_req = 1'b0, rd_req = 1'b0;
  logic [N-1:0] wgo, rgo, wown, rown, sfull, sempty, wxo, rxo;
  logic [PW-1:0] waddr [N];
  logic [PW-1:0] raddr [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_slice
      xchain_ctrl #(.DEPTH(D), .CHAINED(1'b1)) u_xchain_ctrl (
        .clk(clk), .rst(rst), .first_load(1'(i != 0)),
        .wr_xin(wxo[(i+N-1)%N]), .rd_xin(rxo[(i+N-1)%N]),
        .wr_req(wr_req), .rd_req(rd_req), .wr_go(wgo[i]), .rd_go(rgo[i]),
        .wr_addr(waddr[i]), .rd_addr(raddr[i]), .wr_owner(wown[i]),
        .rd_owner(rown[i]), .slice_full(sfull[i]), .slice_empty(sempty[i]),
        .xo_hf(wxo[i]), .rd_xout(rxo[i]));
    end
  endgenerate

  logic s_wgo, s_rgo, s_wown, s_rown, s_full, s_empty, s_xo, s_rxo;
  logic [PW-1:0] s_wa, s_ra;
  xchain_ctrl #(.DEPTH(D), .CHAINED(1'b0)) u_single (
    .clk(clk), .rst(rst), .first_load(1'b0), .wr_xin(1'b0), .rd_xin(1'b0),
    .wr_req(wr_req), .rd_req(rd_req), .wr_go(s_wgo), .rd_go(s_rgo),
    .wr_addr(s_wa), .rd_addr(s_ra), .wr_owner(s_wown), .rd_owner(s_rown),
    .slice_full(s_full), .slice_empty(s_empty), .xo_hf(s_xo), .rd_xout(s_rxo));

  int checks = 0, errors = 0;
  int m_wown[N], m_rown[N], m_wp[N], m_rp[N], m_cnt[N], m_wx[N], m_rx[N];
  int s_cnt, s_wp, s_rp;
  int bm[N][D];
  int exp_q[$];
  int wseq = 0;
  int delivered = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(bit w, bit r);
    int wf[N], rf[N], nwx[N], nrx[N];
    bit sw, sr;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk("R6 write owner", int'(wown[i]), m_wown[i]);
      chk("R6 read owner", int'(rown[i]), m_rown[i]);
      chk("R4 write pulse", int'(wxo[i]), m_wx[i]);
      chk("R5 read pulse", int'(rxo[i]), m_rx[i]);
      chk("R9 full", int'(sfull[i]), int'(m_cnt[i] == D));
      chk("R9 empty", int'(sempty[i]), int'(m_cnt[i] == 0));
      chk("R7 write addr", int'(waddr[i]), m_wp[i]);
      chk("R7 read addr", int'(raddr[i]), m_rp[i]);
    end
    chk("R8 half-full pin", int'(s_xo), int'(s_cnt > D/2));
    chk("R8 no read pulse", int'(s_rxo), 0);
    chk("R8 owners", int'(s_wown && s_rown), 1);
    chk("R7 single addrs", int'(s_wa) * 16 + int'(s_ra), s_wp * 16 + s_rp);
    wr_req = w;
    rd_req = r;
    #1;
    for (int i = 0; i < N; i++) begin
      wf[i] = int'(m_wown[i] != 0 && w && m_cnt[i] < D);
      rf[i] = int'(m_rown[i] != 0 && r && m_cnt[i] > 0);
      chk("R2 write gate", int'(wgo[i]), wf[i]);
      chk("R3 read gate", int'(rgo[i]), rf[i]);
      if (rgo[i]) begin
        if (exp_q.size() == 0) chk("R10 unexpected word", 1, 0);
        else chk("R10 order", bm[i][raddr[i]], exp_q.pop_front());
        delivered++;
      end
      if (wgo[i]) begin
        bm[i][waddr[i]] = wseq;
        exp_q.push_back(wseq);
      end
    end
    if (|wgo) wseq++;
    sw = w && s_cnt < D;
    sr = r && s_cnt > 0;
    chk("R2 single write gate", int'(s_wgo), int'(sw));
    chk("R3 single read gate", int'(s_rgo), int'(sr));
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      nwx[i] = int'(wf[i] != 0 && m_wp[i] == D-1);
      nrx[i] = int'(rf[i] != 0 && m_rp[i] == D-1);
    end
    for (int i = 0; i < N; i++) begin
      if (wf[i] != 0) m_wp[i] = (m_wp[i] + 1) % D;
      if (rf[i] != 0) m_rp[i] = (m_rp[i] + 1) % D;
      m_cnt[i] = m_cnt[i] + wf[i] - rf[i];
      if (nwx[i] != 0) m_wown[i] = 0;
      if (m_wx[(i+N-1)%N] != 0) m_wown[i] = 1;
      if (nrx[i] != 0) m_rown[i] = 0;
      if (m_rx[(i+N-1)%N] != 0) m_rown[i] = 1;
    end
    for (int i = 0; i < N; i++) begin
      m_wx[i] = nwx[i];
      m_rx[i] = nrx[i];
    end
    if (sw) s_wp = (s_wp + 1) % D;
    if (sr) s_rp = (s_rp + 1) % D;
    s_cnt = s_cnt + int'(sw) - int'(sr);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_wown[i] = int'(i == 0); m_rown[i] = int'(i == 0);
      m_wp[i] = 0; m_rp[i] = 0; m_cnt[i] = 0; m_wx[i] = 0; m_rx[i] = 0;
    end
    s_cnt = 0; s_wp = 0; s_rp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen at the ports
    chk("R1 owners after reset", int'(wown) * 8 + int'(rown), 1 * 8 + 1);
    chk("R1 empty after reset", int'(sempty), 7);
    chk("R1 pins low after reset", int'(wxo) + int'(rxo) + int'(s_xo), 0);
    chk("R1 addrs after reset", int'(waddr[0]) + int'(raddr[1]), 0);
    // fill the whole ring: token laps back to a full first slice
    for (int k = 0; k < 20; k++) cycle(1'b1, 1'b0);
    chk("R9 ring full", int'(sfull), 7);
    // drain the ring
    for (int k = 0; k < 20; k++) cycle(1'b0, 1'b1);
    chk("R9 ring empty", int'(sempty), 7);
    // steady mixed patterns
    for (int k = 0; k < 300; k++) cycle(bit'(k % 3 != 0), bit'(k % 2 == 0));
    for (int k = 0; k < 100; k++) cycle(bit'(k % 5 == 0), 1'b1);
    for (int k = 0; k < 400; k++) cycle(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 2) != 0));
    for (int k = 0; k < 40; k++) cycle(1'b0, 1'b1);
    chk("R10 all words delivered", exp_q.size(), 0);
    chk("R10 some words moved", int'(delivered > 50), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule